// File: doc/BRIEF.md
# Light-Load Pulse-Frequency Buck Gate Controller

This block drives the two power switches of a step-down converter while the load is so light that fixed-frequency switching would waste most of the delivered energy. It stays silent, with both switches off, for as long as a one-bit output-voltage comparator reports that the output is high enough. When the comparator asks for charge, the block starts its on-demand pulse timer and fires one burst: a high-side conduction interval, a dead interval, then a low-side conduction interval. After that it returns the stage to high impedance and stops the timer again.

The high-side interval is a fixed fraction of a timing unit. That fraction is the reference code divided by the battery code, computed by a sequential restoring divider. The low-side interval is the volt-second balance of the high-side interval, reduced by an adaptive trim. A zero-crossing detector raises a one-bit flag when coil current has reversed by the end of conduction, and the trim grows on each such flag and relaxes after a long run of clean pulses. The pulse timer is a free-running open-loop divider of the system clock. A slow calibration tick gates measurement windows that nudge the divider so that each window holds a target number of timer ticks.

Top module: `pfm_cot_ctrl`

## Requirements
- R1: After reset, and for as long as the request input stays low and no calibration window is open, `hs_en` and `ls_en` are both 0 and no pulse starts.
- R2: A request seen while idle starts a high-side interval of H timer ticks. H = max(1, floor(F*64/256)), where F = floor(vref*256/vbat) when vref < vbat, and F = 255 otherwise (this includes vbat = 0). A timer tick is D system clocks, and D = 4 after reset.
- R3: F, the low-side length and the dead time are captured when the pulse starts. Changing vref, vbat, dead_cfg or the trim during a pulse does not alter that pulse.
- R4: When `hs_en` falls, both enables stay low for max(dead_cfg,1)*D clocks. Only then does `ls_en` rise.
- R5: The low-side interval lasts (L − T)*D clocks, where L = floor((256−F)*64/256) and T is the trim at pulse start. If L ≤ T, the low-side interval and the dead time are skipped and the stage returns to high impedance right after the high-side interval.
- R6: `hs_en` and `ls_en` are never 1 in the same cycle.
- R7: T starts at 0 and is updated at the end of each low-side interval. It becomes min(T+1,15) when the inversion flag is high there. It becomes max(T−1,0) on the 16th consecutive flag-free low-side end, and that run count then restarts. Any flagged end also restarts the run count. A pulse with a skipped low-side interval leaves both T and the run count unchanged.
- R8: A request that arrives during a pulse is ignored. A held request yields back-to-back pulses, with at least one cycle of both switches off between them.
- R9: Every odd calibration tick opens a measurement window and the following tick closes it. At the close, D rises by 1 if the window counted more than 17 ticks, falls by 1 if it counted fewer than 15, and stays unchanged otherwise. D is limited to the range 1..63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_low | input | 1 | Output-below-threshold request from the comparator (asynchronous) |
| vref_code | input | 8 | Reference voltage code |
| vbat_code | input | 8 | Battery voltage code |
| zc_flag | input | 1 | Current-inversion flag from the zero-crossing detector (asynchronous) |
| cal_tick | input | 1 | Single-cycle slow calibration tick |
| dead_cfg | input | 4 | Dead time in timer ticks (0 is treated as 1) |
| hs_en | output | 1 | High-side switch enable |
| ls_en | output | 1 | Low-side switch enable |

## Verification
The ratio path is tried with a grid of reference and battery codes. The grid covers a quotient small enough to force the one-tick floor, ordinary ratios, a reference above the battery code, and a zero battery code; it separates divider truncation, clamping and the minimum-width rule. The dead time is cycled through 0, 1, 5 and 15 across that grid, so the zero-as-one rule and the tick scaling show up in the gap width. Runs of flagged and then clean pulses walk the trim to its ceiling and back by one. A skipped low-side pulse with the flag high is placed between them, which shows whether skipped pulses touch the trim. Calibration windows of fixed length must move the pulse width from 4 to 6 clocks per tick, which tests both the step rule and the deadband.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HIGH = 2'd1,
      PH_DEAD = 2'd2,
      PH_LOW  = 2'd3
   } phase_t;

endpackage

// File: rtl/pfm_sync.sv
module pfm_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("pfm_sync: W must be at least 1");
   end

   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
               chain_q[i] <= chain_q[i-1];
            end
         end
      end
      assign q_o = chain_q[STAGES-1];
   end

endmodule

// File: rtl/pfm_ratio_div.sv
module pfm_ratio_div #(
   parameter int VW = 8,
   parameter int FW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] num_i,
   input  logic [VW-1:0] den_i,
   output logic [FW-1:0] ratio_o
);

   localparam int SW = $clog2(FW + 1);
   localparam int PW = VW + FW + 1;

   if (VW < 2) begin : g_bad_vw
      $error("pfm_ratio_div: VW must be at least 2");
   end
   if (FW < 2) begin : g_bad_fw
      $error("pfm_ratio_div: FW must be at least 2");
   end

   logic [SW-1:0] step_q;
   logic [VW-1:0] num_q;
   logic [VW-1:0] den_q;
   logic [VW-1:0] rem_q;
   logic [FW-1:0] quo_q;
   logic [FW-1:0] ratio_q;
   logic          sat_q;
   logic          done_q;

   logic [VW:0]   shifted;
   logic [VW:0]   diff;
   logic          fits;
   logic [VW-1:0] rem_nx;
   logic [FW-1:0] quo_nx;

   always_comb begin
      shifted = {rem_q, 1'b0};
      diff    = shifted - {1'b0, den_q};
      fits    = (shifted >= {1'b0, den_q});
      rem_nx  = fits ? VW'(diff) : VW'(shifted);
      quo_nx  = {quo_q[FW-2:0], fits};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= '0;
         num_q   <= '0;
         den_q   <= '0;
         rem_q   <= '0;
         quo_q   <= '0;
         ratio_q <= '0;
         sat_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (step_q == '0) begin
            num_q  <= num_i;
            den_q  <= den_i;
            rem_q  <= num_i;
            sat_q  <= (num_i >= den_i);
            quo_q  <= '0;
            step_q <= SW'(1);
         end else begin
            rem_q <= rem_nx;
            quo_q <= quo_nx;
            if (step_q == SW'(FW)) begin
               step_q  <= '0;
               ratio_q <= sat_q ? '1 : quo_nx;
               done_q  <= 1'b1;
            end else begin
               step_q <= step_q + SW'(1);
            end
         end
      end
   end

   assign ratio_o = ratio_q;

   // R2
   div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !sat_q) |->
         ((PW'(ratio_q) * PW'(den_q) <= (PW'(num_q) << FW)) &&
          ((PW'(ratio_q) + PW'(1)) * PW'(den_q) > (PW'(num_q) << FW))));

   // R2
   div_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && sat_q) |-> (ratio_q == '1));

endmodule

// File: rtl/pfm_tick_timer.sv
module pfm_tick_timer #(
   parameter int DIV_W      = 6,
   parameter int DIV_INIT   = 4,
   parameter bit CAL_EN     = 1'b1,
   parameter int CAL_TARGET = 16,
   parameter int CAL_BAND   = 1,
   parameter int CNT_W      = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic cal_tick_i,
   output logic tick_o,
   output logic cal_open_o
);

   localparam int DIV_MAX = (1 << DIV_W) - 1;
   localparam int HI_LIM  = CAL_TARGET + CAL_BAND;
   localparam int LO_LIM  = CAL_TARGET - CAL_BAND;

   if (DIV_INIT < 1 || DIV_INIT > DIV_MAX) begin : g_bad_init
      $error("pfm_tick_timer: DIV_INIT out of range");
   end
   if (LO_LIM < 1 || HI_LIM >= (1 << CNT_W) - 1) begin : g_bad_cal
      $error("pfm_tick_timer: calibration window limits do not fit");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] pre_q;
   logic             open_w;
   logic             run_all;
   logic             wrap;

   assign run_all = run_i | open_w;
   assign wrap    = (pre_q == div_q - DIV_W'(1));
   assign tick_o  = run_all & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (!run_all || wrap) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + DIV_W'(1);
      end
   end

   if (CAL_EN) begin : g_cal
      logic             open_q;
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
            div_q  <= DIV_W'(DIV_INIT);
         end else if (cal_tick_i) begin
            if (!open_q) begin
               open_q <= 1'b1;
               cnt_q  <= '0;
            end else begin
               open_q <= 1'b0;
               if (cnt_q > CNT_W'(HI_LIM) && div_q != DIV_W'(DIV_MAX)) begin
                  div_q <= div_q + DIV_W'(1);
               end else if (cnt_q < CNT_W'(LO_LIM) && div_q != DIV_W'(1)) begin
                  div_q <= div_q - DIV_W'(1);
               end
            end
         end else if (open_q && tick_o && cnt_q != '1) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end

      assign open_w = open_q;

      // R9
      div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (div_q >= DIV_W'(1)));

      // R9
      div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (div_q != $past(div_q)) |-> ($past(cal_tick_i) && !open_q));
   end else begin : g_fixed
      assign div_q  = DIV_W'(DIV_INIT);
      assign open_w = 1'b0;
   end

   assign cal_open_o = open_w;

endmodule

// File: rtl/pfm_trim.sv
module pfm_trim #(
   parameter int TRIM_W    = 4,
   parameter int TRIM_MAX  = 15,
   parameter int CLEAN_RUN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              end_i,
   input  logic              inv_i,
   output logic [TRIM_W-1:0] trim_o
);

   localparam int RW = $clog2(CLEAN_RUN);

   if (TRIM_MAX < 1 || TRIM_MAX >= (1 << TRIM_W)) begin : g_bad_max
      $error("pfm_trim: TRIM_MAX does not fit TRIM_W");
   end
   if (CLEAN_RUN < 2) begin : g_bad_run
      $error("pfm_trim: CLEAN_RUN must be at least 2");
   end

   logic [TRIM_W-1:0] trim_q;
   logic [RW-1:0]     run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trim_q <= '0;
         run_q  <= '0;
      end else if (end_i) begin
         if (inv_i) begin
            run_q <= '0;
            if (trim_q != TRIM_W'(TRIM_MAX)) begin
               trim_q <= trim_q + TRIM_W'(1);
            end
         end else if (run_q == RW'(CLEAN_RUN - 1)) begin
            run_q <= '0;
            if (trim_q != '0) begin
               trim_q <= trim_q - TRIM_W'(1);
            end
         end else begin
            run_q <= run_q + RW'(1);
         end
      end
   end

   assign trim_o = trim_q;

   // R7
   trim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trim_q <= TRIM_W'(TRIM_MAX)));

   // R7
   trim_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trim_q != $past(trim_q)) |-> $past(end_i));

endmodule

// File: rtl/pfm_cot_ctrl.sv
module pfm_cot_ctrl #(
   parameter int VW          = 8,
   parameter int FW          = 8,
   parameter int UNIT_TICKS  = 64,
   parameter int DT_W        = 4,
   parameter int DIV_W       = 6,
   parameter int DIV_INIT    = 4,
   parameter bit CAL_EN      = 1'b1,
   parameter int CAL_TARGET  = 16,
   parameter int CAL_BAND    = 1,
   parameter int CAL_CNT_W   = 8,
   parameter int TRIM_W      = 4,
   parameter int TRIM_MAX    = 15,
   parameter int CLEAN_RUN   = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmp_low,
   input  logic [VW-1:0]   vref_code,
   input  logic [VW-1:0]   vbat_code,
   input  logic            zc_flag,
   input  logic            cal_tick,
   input  logic [DT_W-1:0] dead_cfg,
   output logic            hs_en,
   output logic            ls_en
);

   import pfm_pkg::*;

   localparam int TW = $clog2(UNIT_TICKS + 1);
   localparam int CW = (TW > DT_W) ? TW : DT_W;
   localparam int PW = FW + TW + 1;

   if (UNIT_TICKS < 2) begin : g_bad_unit
      $error("pfm_cot_ctrl: UNIT_TICKS must be at least 2");
   end
   if (TRIM_W > TW || TRIM_MAX >= UNIT_TICKS) begin : g_bad_trim
      $error("pfm_cot_ctrl: trim range exceeds timing unit");
   end

   logic [1:0]        sync_q;
   logic              req_s;
   logic              inv_s;
   logic [FW-1:0]     frac;
   logic              tick;
   logic              cal_open;
   logic [TRIM_W-1:0] trim;

   pfm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({zc_flag, cmp_low}),
      .q_o   (sync_q)
   );
   assign req_s = sync_q[0];
   assign inv_s = sync_q[1];

   pfm_ratio_div #(.VW(VW), .FW(FW)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .num_i   (vref_code),
      .den_i   (vbat_code),
      .ratio_o (frac)
   );

   phase_t          phase_q;
   logic [CW-1:0]   tcnt_q;
   logic [TW-1:0]   ls_q;
   logic            skip_q;
   logic [DT_W-1:0] dt_q;

   logic            busy;
   logic            last_tick;
   logic            low_end;

   assign busy      = (phase_q != PH_IDLE);
   assign last_tick = tick && (tcnt_q == CW'(1));
   assign low_end   = (phase_q == PH_LOW) && last_tick;

   pfm_tick_timer #(
      .DIV_W      (DIV_W),
      .DIV_INIT   (DIV_INIT),
      .CAL_EN     (CAL_EN),
      .CAL_TARGET (CAL_TARGET),
      .CAL_BAND   (CAL_BAND),
      .CNT_W      (CAL_CNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (busy),
      .cal_tick_i (cal_tick),
      .tick_o     (tick),
      .cal_open_o (cal_open)
   );

   pfm_trim #(
      .TRIM_W    (TRIM_W),
      .TRIM_MAX  (TRIM_MAX),
      .CLEAN_RUN (CLEAN_RUN)
   ) u_trim (
      .clk    (clk),
      .rst_n  (rst_n),
      .end_i  (low_end),
      .inv_i  (inv_s),
      .trim_o (trim)
   );

   logic [PW-1:0]   hs_prod;
   logic [PW-1:0]   ls_prod;
   logic [TW-1:0]   hs_raw;
   logic [TW-1:0]   hs_calc;
   logic [TW-1:0]   ls_raw;
   logic [TW-1:0]   trim_ext;
   logic [TW-1:0]   ls_calc;
   logic            ls_skip;
   logic [DT_W-1:0] dt_eff;

   always_comb begin
      hs_prod  = PW'(frac) * PW'(UNIT_TICKS);
      ls_prod  = ((PW'(1) << FW) - PW'(frac)) * PW'(UNIT_TICKS);
      hs_raw   = TW'(hs_prod >> FW);
      ls_raw   = TW'(ls_prod >> FW);
      hs_calc  = (hs_raw == '0) ? TW'(1) : hs_raw;
      trim_ext = TW'(trim);
      ls_skip  = (ls_raw <= trim_ext);
      ls_calc  = ls_raw - trim_ext;
      dt_eff   = (dead_cfg == '0) ? DT_W'(1) : dead_cfg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         tcnt_q  <= '0;
         ls_q    <= '0;
         skip_q  <= 1'b0;
         dt_q    <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (req_s) begin
                  phase_q <= PH_HIGH;
                  tcnt_q  <= CW'(hs_calc);
                  ls_q    <= ls_calc;
                  skip_q  <= ls_skip;
                  dt_q    <= dt_eff;
               end
            end
            PH_HIGH: begin
               if (last_tick) begin
                  if (skip_q) begin
                     phase_q <= PH_IDLE;
                  end else begin
                     phase_q <= PH_DEAD;
                     tcnt_q  <= CW'(dt_q);
                  end
               end else if (tick) begin
                  tcnt_q <= tcnt_q - CW'(1);
               end
            end
            PH_DEAD: begin
               if (last_tick) begin
                  phase_q <= PH_LOW;
                  tcnt_q  <= CW'(ls_q);
               end else if (tick) begin
                  tcnt_q <= tcnt_q - CW'(1);
               end
            end
            PH_LOW: begin
               if (last_tick) begin
                  phase_q <= PH_IDLE;
               end else if (tick) begin
                  tcnt_q <= tcnt_q - CW'(1);
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign hs_en = (phase_q == PH_HIGH);
   assign ls_en = (phase_q == PH_LOW);

   // R6
   never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en && ls_en));

   // R4
   dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_en) |-> !$past(hs_en));

   // R8
   fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> !$past(ls_en));

   // R3
   capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(ls_q) && $stable(dt_q) && $stable(skip_q)));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cal_open) |-> !tick);

endmodule

// File: tb/pfm_cot_ctrl_bench.sv
`timescale 1ns/1ps
module pfm_cot_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_low = 1'b0;
   logic [7:0] vref_code = 8'd0;
   logic [7:0] vbat_code = 8'd0;
   logic       zc_flag = 1'b0;
   logic       cal_tick = 1'b0;
   logic [3:0] dead_cfg = 4'd1;
   logic       hs_en;
   logic       ls_en;

   always #5 clk = ~clk;

   pfm_cot_ctrl u_pfm_cot_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmp_low   (cmp_low),
      .vref_code (vref_code),
      .vbat_code (vbat_code),
      .zc_flag   (zc_flag),
      .cal_tick  (cal_tick),
      .dead_cfg  (dead_cfg),
      .hs_en     (hs_en),
      .ls_en     (ls_en)
   );

   int total_n = 0;
   int bad_n   = 0;

   // port monitor state
   int hs_n = 0, ls_n = 0, overlap_n = 0;
   int hs_cnt = 0, ls_cnt = 0, gap_cnt = 0, idle_cnt = 0;
   int hs_w = 0, ls_w = 0, gap_w = 0, idle_w = 0;
   bit prev_hs = 0, prev_ls = 0, in_gap = 0;
   // reference model of the trim
   int trim_m = 0, clean_m = 0, trim_snap = 0;
   int div_m = 4;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total_n++;
      if (!ok) begin
         bad_n++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (hs_en && ls_en) overlap_n++;
         if (hs_en && !prev_hs) begin
            hs_n++;
            idle_w = idle_cnt;
            trim_snap = trim_m;
         end
         if (hs_en) hs_cnt++;
         else if (prev_hs) begin
            hs_w = hs_cnt; hs_cnt = 0; in_gap = 1; gap_cnt = 0;
         end
         if (in_gap && !hs_en && !ls_en) gap_cnt++;
         if (ls_en && !prev_ls) begin
            gap_w = gap_cnt; in_gap = 0;
         end
         if (ls_en) ls_cnt++;
         else if (prev_ls) begin
            ls_w = ls_cnt; ls_cnt = 0; ls_n++;
            if (zc_flag) begin
               trim_m = (trim_m < 15) ? trim_m + 1 : 15;
               clean_m = 0;
            end else begin
               clean_m++;
               if (clean_m == 16) begin
                  clean_m = 0;
                  trim_m = (trim_m > 0) ? trim_m - 1 : 0;
               end
            end
         end
         if (!hs_en && !ls_en) idle_cnt++;
         else idle_cnt = 0;
         prev_hs = hs_en;
         prev_ls = ls_en;
      end
   end

   function automatic int frac_of(input int vr, input int vb);
      if (vr >= vb) return 255;
      return (vr * 256) / vb;
   endfunction

   // one pulse with full width checks; vb_mid >= 0 changes vbat during HS,
   // poke raises a short request during HS
   task automatic run_pulse(input int vr, input int vb, input int dt, input bit zc,
                            input int vb_mid, input bit poke);
      int n0, l0, fr, hs_t, ls_raw, ls_t, dt_t;
      vref_code = 8'(vr);
      vbat_code = 8'(vb);
      dead_cfg  = 4'(dt);
      zc_flag   = zc;
      repeat (40) tick();
      n0 = hs_n;
      l0 = ls_n;
      cmp_low = 1'b1;
      while (hs_n == n0) tick();
      cmp_low = 1'b0;
      fr     = frac_of(vr, vb);
      hs_t   = (fr * 64) / 256;
      if (hs_t == 0) hs_t = 1;
      ls_raw = ((256 - fr) * 64) / 256;
      ls_t   = ls_raw - trim_snap;
      dt_t   = (dt == 0) ? 1 : dt;
      if (vb_mid >= 0) begin
         repeat (5) tick();
         vbat_code = 8'(vb_mid);
         dead_cfg  = 4'd15;
      end
      if (poke) begin
         repeat (10) tick();
         cmp_low = 1'b1;
         repeat (3) tick();
         cmp_low = 1'b0;
      end
      while (hs_en) tick();
      // R2 high-side width
      check(hs_w == hs_t * div_m, "R2 high-side width", hs_w, hs_t * div_m);
      if (ls_t <= 0) begin
         repeat (30 * div_m) tick();
         // R5 low side skipped
         check(ls_n == l0, "R5 low side skipped", ls_n - l0, 0);
      end else begin
         while (ls_n == l0) tick();
         // R4 dead gap
         check(gap_w == dt_t * div_m, "R4 dead gap", gap_w, dt_t * div_m);
         // R5 low-side width
         check(ls_w == ls_t * div_m, "R5 low-side width", ls_w, ls_t * div_m);
      end
   endtask

   initial begin
      #1_500_000;
      total_n++;
      bad_n++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
   end

   initial begin
      int vbs[4];
      int vrs[3];
      int dts[4];
      int n0, l0;
      vbs = '{60, 120, 200, 255};
      vrs = '{1, 20, 50};
      dts = '{0, 1, 5, 15};

      // R1 reset state
      repeat (4) tick();
      check(hs_en == 0 && ls_en == 0, "R1 outputs in reset", {hs_en, ls_en}, 0);
      rst_n = 1'b1;
      vref_code = 8'd64;
      vbat_code = 8'd128;
      repeat (120) tick();
      check(hs_n == 0 && ls_n == 0, "R1 no pulse without request", hs_n + ls_n, 0);
      check(hs_en == 0 && ls_en == 0, "R1 idle outputs off", {hs_en, ls_en}, 0);

      // R2 R4 R5 ratio and dead-time sweep
      for (int i = 0; i < 4; i++) begin
         for (int j = 0; j < 3; j++) begin
            run_pulse(vrs[j], vbs[i], dts[(i + j) % 4], 1'b0, -1, 1'b0);
         end
      end

      // R2 clamp when reference is not below battery, and zero battery code
      run_pulse(200, 100, 3, 1'b0, -1, 1'b0);
      run_pulse(10, 0, 3, 1'b0, -1, 1'b0);

      // R3 mid-pulse change of battery code and dead time
      run_pulse(64, 128, 2, 1'b0, 255, 1'b0);

      // R7 inversion flag raises trim to its ceiling
      for (int k = 0; k < 18; k++) run_pulse(64, 128, 1, 1'b1, -1, 1'b0);
      check(trim_m == 15, "R7 trim ceiling reached", trim_m, 15);
      // R7 sixteen clean pulses lower trim by one
      for (int k = 0; k < 16; k++) run_pulse(64, 128, 1, 1'b0, -1, 1'b0);
      check(trim_m == 14, "R7 trim relaxed once", trim_m, 14);
      // R7 skipped low side with flag high leaves trim alone
      run_pulse(230, 255, 1, 1'b1, -1, 1'b0);
      run_pulse(64, 128, 1, 1'b0, -1, 1'b0);
      check(ls_w == (32 - 14) * div_m, "R7 trim unchanged by skipped pulse", ls_w, (32 - 14) * div_m);

      // R8 request during pulse is ignored
      n0 = hs_n;
      run_pulse(64, 128, 2, 1'b0, -1, 1'b1);
      repeat (300) tick();
      check(hs_n == n0 + 1, "R8 request during pulse ignored", hs_n - n0, 1);

      // R8 held request gives back-to-back pulses with an idle cycle
      n0 = hs_n;
      l0 = ls_n;
      cmp_low = 1'b1;
      while (hs_n < n0 + 2) tick();
      cmp_low = 1'b0;
      check(idle_w >= 1, "R8 idle cycle between pulses", idle_w, 1);
      while (ls_n < l0 + 2) tick();
      check(ls_w == (32 - trim_snap) * div_m, "R8 back-to-back low-side width", ls_w, (32 - trim_snap) * div_m);
      repeat (40) tick();

      // R9 calibration: windows of 96 clocks move the divider from 4 to 6
      for (int p = 0; p < 4; p++) begin
         cal_tick = 1'b1; tick(); cal_tick = 1'b0;
         repeat (95) tick();
         cal_tick = 1'b1; tick(); cal_tick = 1'b0;
         repeat (20) tick();
      end
      div_m = 6;
      run_pulse(64, 128, 2, 1'b0, -1, 1'b0);
      run_pulse(1, 255, 0, 1'b0, -1, 1'b0);

      // R6 no overlap across the whole run
      check(overlap_n == 0, "R6 switches never both on", overlap_n, 0);

      $display("test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
   end

endmodule